// File: doc/BRIEF.md
# Word-to-Byte Receive Readout Buffer

This block sits between a serial word receiver and a host with an 8-bit data bus. Each time the receiver hands over a complete 32-bit word with a one-cycle load strobe, the block stores it, raises a ready flag and resets its byte selector. The host then fetches the word as four byte reads by pulsing an active-low read strobe. The bus is modelled as an output enable plus a data byte, and the enable is asserted only while the strobe is low.

The byte selector is a four-state machine with states SEL_B1, SEL_B2, SEL_B3 and SEL_B4. Its transitions are as follows. Any state goes to SEL_B1 on a load. On the end of a read pulse (strobe rising), the machine steps SEL_B1→SEL_B2, SEL_B2→SEL_B3, SEL_B3→SEL_B4 and SEL_B4→SEL_B1 (wrap). Otherwise it holds its state. The ready flag is cleared by the start of the read pulse that fetches the first byte. A load always overwrites the stored word, even if the previous word was never read or was only partly read.

Top module: `byte_readout_buffer`

## Requirements
- R1: After reset, `data_rdy` is 0, the stored word is zero and the selector is at SEL_B1, so the first read returns bits 1 to 8.
- R2: `bus_oe` is 1 exactly while `rd_n` is 0. While `bus_oe` is 0, `bus_data` is all zeros.
- R3: Word bit k (k=1..32) is input bit `word_in[k-1]`. Read n (n=1..4) returns bits 8n-7 to 8n on `bus_data[7:0]`, which is `word_in[8n-1:8n-8]`, with the lowest-numbered bit on `bus_data[0]`.
- R4: A clock edge with `load` high stores `word_in` and sets `data_rdy` to 1 from the next cycle.
- R5: A falling edge of `rd_n` seen while the selector is at SEL_B1, with no load in the same cycle, clears `data_rdy` from the next cycle.
- R6: A rising edge of `rd_n` with no load in the same cycle advances the selector by one byte, and SEL_B4 wraps to SEL_B1.
- R7: Every load replaces the stored word, whether or not the previous word was read.
- R8: A load returns the selector to SEL_B1 in the middle of a read sequence, so the next read returns byte 1 of the new word.
- R9: When a load and the end of a read pulse coincide, the load wins: the selector goes to SEL_B1 and `data_rdy` is set.
- R10: When a load and the start of a read pulse coincide, the load wins and `data_rdy` ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Word hand-over strobe from the receiver |
| word_in | input | 32 | Received word; bit k-1 holds word bit k |
| rd_n | input | 1 | Active-low host read strobe, synchronous to clk |
| bus_data | output | 8 | Selected byte, zero while not enabled |
| bus_oe | output | 1 | Bus drive enable (high while reading) |
| data_rdy | output | 1 | A new word is waiting to be read |

## Verification
The assertions assume that `rd_n` and `load` are synchronous to `clk` and stable around each rising edge. They also assume that `load` is a plain level sampled every cycle, so two back-to-back loads count as two loads. The stimulus changes every input 1 ns after the falling clock edge. Read pulses are at least one cycle low and one cycle high, except where the directed cases align a load with an edge of the strobe on purpose. The random phase keeps to the same synchronous discipline and draws strobe levels and loads freely, including loads in the middle of a pulse.

// File: rtl/rbuf_pkg.sv
package rbuf_pkg;
    parameter int BYTE_W    = 8;
    parameter int NUM_BYTES = 4;
    localparam int WORD_W   = BYTE_W * NUM_BYTES;
    localparam int SEL_W    = $clog2(NUM_BYTES);

    typedef enum logic [SEL_W-1:0] {
        SEL_B1 = 2'd0,
        SEL_B2 = 2'd1,
        SEL_B3 = 2'd2,
        SEL_B4 = 2'd3
    } sel_e;
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_n,
    output logic rd_fall,
    output logic rd_rise
);
    logic rd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 1'b1;
        else        rd_q <= rd_n;
    end

    assign rd_fall = rd_q & ~rd_n;
    assign rd_rise = ~rd_q & rd_n;

    // R6
    rise_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rise |-> $past(rd_n) == 1'b0 || !$past(rst_n));
endmodule

// File: rtl/readout_fsm.sv
module readout_fsm
    import rbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic rd_fall,
    input  logic rd_rise,
    output sel_e sel,
    output logic rdy
);
    sel_e sel_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) sel <= SEL_B1;
        else        sel <= sel_nxt;
    end

    always_comb begin
        sel_nxt = sel;
        if (load) begin
            sel_nxt = SEL_B1;
        end else if (rd_rise) begin
            unique case (sel)
                SEL_B1: sel_nxt = SEL_B2;
                SEL_B2: sel_nxt = SEL_B3;
                SEL_B3: sel_nxt = SEL_B4;
                SEL_B4: sel_nxt = SEL_B1;
                default: sel_nxt = SEL_B1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                         rdy <= 1'b0;
        else if (load)                      rdy <= 1'b1;
        else if (rd_fall && sel == SEL_B1)  rdy <= 1'b0;
    end

    // R4
    load_sets_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> rdy && sel == SEL_B1);
    // R5
    first_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fall && sel == SEL_B1 && !load) |=> !rdy);
    // R6
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rise && !load) |=> sel != $past(sel));
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_rise && !load) |=> $stable(sel));
endmodule

// File: rtl/word_store.sv
module word_store #(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 4,
    localparam int WORD_W   = BYTE_W * NUM_BYTES,
    localparam int SEL_W    = $clog2(NUM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  logic [SEL_W-1:0]  sel,
    output logic [BYTE_W-1:0] byte_out
);
    logic [WORD_W-1:0] store;
    logic [BYTE_W-1:0] lane [NUM_BYTES];

    always_ff @(posedge clk) begin
        if (!rst_n)    store <= '0;
        else if (load) store <= word_in;
    end

    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_lane
        assign lane[i] = store[i*BYTE_W +: BYTE_W];
    end

    assign byte_out = lane[sel];

    // R7
    overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> store == $past(word_in));
    // R7
    keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(store));
endmodule

// File: rtl/byte_readout_buffer.sv
module byte_readout_buffer
    import rbuf_pkg::*;
#(
    parameter int BYTE_W   = rbuf_pkg::BYTE_W,
    localparam int WORD_W  = BYTE_W * NUM_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  logic              rd_n,
    output logic [BYTE_W-1:0] bus_data,
    output logic              bus_oe,
    output logic              data_rdy
);
    logic              rd_fall;
    logic              rd_rise;
    sel_e              sel;
    logic [BYTE_W-1:0] byte_sel;

    strobe_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_n    (rd_n),
        .rd_fall (rd_fall),
        .rd_rise (rd_rise)
    );

    readout_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .rd_fall (rd_fall),
        .rd_rise (rd_rise),
        .sel     (sel),
        .rdy     (data_rdy)
    );

    word_store #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .word_in  (word_in),
        .sel      (sel),
        .byte_out (byte_sel)
    );

    assign bus_oe   = ~rd_n;
    assign bus_data = bus_oe ? byte_sel : '0;

    // R3
    first_byte_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(load) && bus_oe) |-> bus_data == $past(word_in[BYTE_W-1:0]));
    // R8
    load_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> sel == SEL_B1);
endmodule

// File: tb/byte_readout_buffer_test.sv
`timescale 1ns/1ps
module byte_readout_buffer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [31:0] word_in = '0;
    logic        rd_n = 1'b1;
    logic [7:0]  bus_data;
    logic        bus_oe;
    logic        data_rdy;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] m_word = '0;
    int          m_idx  = 0;
    logic        m_rdy  = 1'b0;
    logic        m_prev = 1'b1;

    byte_readout_buffer uut (
        .clk(clk), .rst_n(rst_n), .load(load), .word_in(word_in),
        .rd_n(rd_n), .bus_data(bus_data), .bus_oe(bus_oe), .data_rdy(data_rdy)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_word = '0; m_idx = 0; m_rdy = 1'b0; m_prev = 1'b1;
        end else begin
            if (load) begin
                m_word = word_in; m_idx = 0; m_rdy = 1'b1;
            end else begin
                if (m_prev && !rd_n && m_idx == 0) m_rdy = 1'b0;
                if (!m_prev && rd_n) m_idx = (m_idx + 1) % 4;
            end
            m_prev = rd_n;
        end
    end

    // every-cycle comparison, away from the rising edge
    always @(negedge clk) begin
        chk("R1/R4/R5/R9/R10 data_rdy", data_rdy, m_rdy);
        chk("R2 bus_oe", bus_oe, !rd_n);
        chk("R2/R3/R6/R8 bus_data", bus_data, rd_n ? 0 : int'(m_word[m_idx*8 +: 8]));
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic put_word(input logic [31:0] w);
        step(); load = 1'b1; word_in = w;
        step(); load = 1'b0;
    endtask

    task automatic read_byte(output logic [7:0] b);
        step(); rd_n = 1'b0;
        #1 b = bus_data;
        step(); rd_n = 1'b1;
    endtask

    logic [7:0] got;

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 rdy after reset", data_rdy, 0);
        read_byte(got);
        chk("R1 first read after reset", got, 0);
        rst_n = 1'b0; step(); rst_n = 1'b1;

        put_word(32'hA4B3_C2D1);
        chk("R4 rdy after load", data_rdy, 1);
        read_byte(got); chk("R3 byte1", got, 8'hD1);
        chk("R5 rdy cleared by first read", data_rdy, 0);
        read_byte(got); chk("R3 byte2", got, 8'hC2);
        read_byte(got); chk("R3 byte3", got, 8'hB3);
        read_byte(got); chk("R3 byte4", got, 8'hA4);
        read_byte(got); chk("R6 wrap to byte1", got, 8'hD1);
        step();
        chk("R2 idle bus zero", bus_data, 0);

        put_word(32'h1111_1111);
        put_word(32'h5566_7788);
        read_byte(got); chk("R7 unread word replaced", got, 8'h88);
        read_byte(got); chk("R7 second byte", got, 8'h77);

        put_word(32'h0F1E_2D3C);
        read_byte(got); chk("R8 byte1 before reload", got, 8'h3C);
        put_word(32'hCAFE_F00D);
        read_byte(got); chk("R8 restart at byte1", got, 8'h0D);

        step(); rd_n = 1'b0;
        step(); rd_n = 1'b1; load = 1'b1; word_in = 32'h9988_7766;
        step(); load = 1'b0;
        chk("R9 load wins over pulse end rdy", data_rdy, 1);
        read_byte(got); chk("R9 selector at byte1", got, 8'h66);

        step(); rd_n = 1'b0; load = 1'b1; word_in = 32'h4433_2211;
        step(); load = 1'b0;
        #1 chk("R10 coincident read sees byte1", bus_data, 8'h11);
        chk("R10 load wins over pulse start", data_rdy, 1);
        step(); rd_n = 1'b1;
        read_byte(got); chk("R10 next byte", got, 8'h22);

        for (int i = 0; i < 400; i++) begin
            step();
            rd_n = ($urandom % 3) != 0;
            load = ($urandom % 9) == 0;
            word_in = $urandom;
        end
        step(); load = 1'b0; rd_n = 1'b1;
        step();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule